// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block sits between a set of external request lines and an interrupt distributor. Each line is brought into the block clock domain through a two-flop synchronizer. It is then judged by a per-line sense rule: active-low level, active-high level, falling edge, rising edge, or either edge. A hit sets a sticky detect bit. Software clears that bit by writing a one to it.

A per-line enable, with separate set and clear write addresses, gates each detect bit onto its own interrupt output. A 32-bit register port gives software access to the enables, detect bits, request status, configuration words and a raw level monitor. Writes take effect on the rising clock edge at which `bus_wr` is high. Reads are combinational from `bus_addr`. All offsets are byte addresses with bits [1:0] ignored.

Top module: `extint_sense_ctrl`

## Requirements
- R1: After reset every enable, detect and configuration bit is zero, every interrupt output is low, and all readable registers return zero.
- R2: A write to offset 0x08 sets each enable bit whose data bit is 1 and leaves the others unchanged. Reads of 0x04 and 0x08 both return the enable vector.
- R3: A write to offset 0x04 clears each enable bit whose data bit is 1 and leaves the others unchanged.
- R4: Offset 0x100 reads the detect bits. Writing 1 to a bit clears it, writing 0 has no effect, and a detect bit falls only through such a write.
- R5: Offset 0x00 reads detect AND enable, and output `irq_out[n]` is high exactly when detect bit n and enable bit n are both 1.
- R6: Offset 0x104 returns each input after the two-flop synchronizer: a level applied before edge k reads back after edge k+1 and not after edge k.
- R7: Line n has a 32-bit read/write configuration word at 0x180 + 4*n. Only bits [5:0] select sensing; bits [31:6] are plain storage.
- R8: The sense field values are 0x01 low level, 0x02 high level, 0x04 falling edge, 0x08 rising edge and 0x0C both edges. For an input change applied before edge k, the detect bit is set at edge k+2 and is still clear after edge k+1.
- R9: In a level mode the detect bit stays set, and re-sets after a clear, while the active level persists. Once the level is gone, a clear leaves it at zero.
- R10: A line whose sense field [5:0] is zero never sets its detect bit.
- R11: When a hardware hit and a W1C clear of the same detect bit fall in the same cycle, the bit ends set.
- R12: Reads of unmapped offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | NUM_LINES | External request lines, asynchronous |
| irq_out | output | NUM_LINES | Per-line gated interrupt outputs |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |

## Verification
Each sense mode is driven with a rising pulse, a falling pulse and a held level on a line of its own. This separates edge rules from level rules and shows that each edge rule responds to one direction only. A line with a zero sense field receives the same toggles and must stay silent. A level line is cleared while its level is still held and again after the level is removed, which tells persistence apart from stickiness. A clear timed onto the very edge of a fresh rising hit shows the set-over-clear priority, and the latency probes pin the synchronizer depth to exactly two stages.

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_in,
  output logic [NUM_LINES-1:0] irq_out,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata
);
  localparam logic [ADDR_W-1:0] OFS_REQ   = ADDR_W'(9'h000);
  localparam logic [ADDR_W-1:0] OFS_ENCLR = ADDR_W'(9'h004);
  localparam logic [ADDR_W-1:0] OFS_ENSET = ADDR_W'(9'h008);
  localparam logic [ADDR_W-1:0] OFS_DET   = ADDR_W'(9'h100);
  localparam logic [ADDR_W-1:0] OFS_MON   = ADDR_W'(9'h104);
  localparam int                CFG_HI_W  = ADDR_W - 7;

  logic [NUM_LINES-1:0] sync1, sync2, prev;
  logic [NUM_LINES-1:0] en, det, hit, sense_live;
  logic [31:0]          cfg [NUM_LINES];

  logic [ADDR_W-1:0] word_addr;
  logic              cfg_sel;
  logic [4:0]        cfg_idx;
  logic              cfg_ok;

  assign word_addr = {bus_addr[ADDR_W-1:2], 2'b00};
  assign cfg_sel   = bus_addr[ADDR_W-1:7] == CFG_HI_W'(3);
  assign cfg_idx   = bus_addr[6:2];
  assign cfg_ok    = cfg_sel && (int'(cfg_idx) < NUM_LINES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= line_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign hit[i] = (cfg[i][0] & ~sync2[i])
                  | (cfg[i][1] &  sync2[i])
                  | (cfg[i][2] &  prev[i] & ~sync2[i])
                  | (cfg[i][3] & ~prev[i] &  sync2[i]);
    assign sense_live[i] = |cfg[i][5:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0;
    end else if (bus_wr && word_addr == OFS_ENSET) begin
      en <= en | bus_wdata[NUM_LINES-1:0];
    end else if (bus_wr && word_addr == OFS_ENCLR) begin
      en <= en & ~bus_wdata[NUM_LINES-1:0];
    end
  end

  logic [NUM_LINES-1:0] det_clr;
  assign det_clr = (bus_wr && word_addr == OFS_DET) ? bus_wdata[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) det <= '0;
    else        det <= (det & ~det_clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) cfg[i] <= '0;
    end else if (bus_wr && cfg_ok) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (int'(cfg_idx) == i) cfg[i] <= bus_wdata;
    end
  end

  assign irq_out = det & en;

  always_comb begin
    bus_rdata = '0;
    if (cfg_ok) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (int'(cfg_idx) == i) bus_rdata = cfg[i];
    end else begin
      case (word_addr)
        OFS_REQ:   bus_rdata = 32'(det & en);
        OFS_ENCLR: bus_rdata = 32'(en);
        OFS_ENSET: bus_rdata = 32'(en);
        OFS_DET:   bus_rdata = 32'(det);
        OFS_MON:   bus_rdata = 32'(sync2);
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/extint_sense_chk.sv
module extint_sense_chk #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] line_in,
  input logic [NUM_LINES-1:0] irq_out,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic [31:0]          bus_wdata,
  input logic [NUM_LINES-1:0] en,
  input logic [NUM_LINES-1:0] det,
  input logic [NUM_LINES-1:0] mon,
  input logic [NUM_LINES-1:0] sense_live
);
  logic [ADDR_W-1:0] wa;
  logic [1:0]        cyc;
  assign wa = {bus_addr[ADDR_W-1:2], 2'b00};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        cyc <= '0;
    else if (cyc != 2) cyc <= cyc + 2'd1;

  assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && wa == ADDR_W'(9'h008)) |=>
      ((en & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0])));

  assert_enable_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && wa == ADDR_W'(9'h004)) |=> ((en & $past(bus_wdata[NUM_LINES-1:0])) == '0));

  assert_monitor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2) |-> (mon == $past(line_in, 2)));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
    assert_det_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(det[i]) |-> $past(bus_wr && wa == ADDR_W'(9'h100) && bus_wdata[i]));
    assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[i] |-> (en[i] && det[i]));
    assert_sense_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(det[i]) |-> $past(sense_live[i]));
  end
endmodule

bind extint_sense_ctrl extint_sense_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_in(line_in), .irq_out(irq_out),
  .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .en(en), .det(det), .mon(sync2), .sense_live(sense_live)
);

// File: tb/tb_extint_sense_ctrl.sv
module tb_extint_sense_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] line_in = '0;
  logic [31:0] irq_out;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  extint_sense_ctrl dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .irq_out(irq_out),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [8:0] cfg_a(input int n);
    return 9'(9'h180 + 4 * n);
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(9'h000, d); check("R1 req", d, 0);
    rd(9'h004, d); check("R1 enable", d, 0);
    rd(9'h100, d); check("R1 detect", d, 0);
    rd(9'h104, d); check("R1 monitor", d, 0);
    rd(cfg_a(9), d); check("R1 config", d, 0);
    check("R1 irq_out", irq_out, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(9'h008, 32'h0000_00F0);
    rd(9'h004, d); check("R2 set", d, 32'hF0);
    wr(9'h008, 32'h0000_000F);
    rd(9'h008, d); check("R2 zero bits keep", d, 32'hFF);
    wr(9'h004, 32'h0000_0030);
    rd(9'h004, d); check("R3 clear", d, 32'hCF);
    wr(9'h004, 32'hFFFF_FFFF);
    rd(9'h008, d); check("R3 clear all", d, 0);
  endtask

  task automatic t_config_unmapped;
    logic [31:0] d;
    wr(cfg_a(5), 32'hFFFF_FFC0);
    rd(cfg_a(5), d); check("R7 storage", d, 32'hFFFF_FFC0);
    rd(cfg_a(4), d); check("R7 neighbour", d, 0);
    wr(9'h00C, 32'hFFFF_FFFF);
    wr(9'h17C, 32'hFFFF_FFFF);
    rd(9'h00C, d); check("R12 read 0x0C", d, 0);
    rd(9'h10C, d); check("R12 read 0x10C", d, 0);
    rd(9'h004, d); check("R12 enable untouched", d, 0);
    rd(9'h100, d); check("R12 detect untouched", d, 0);
    rd(cfg_a(5), d); check("R12 config untouched", d, 32'hFFFF_FFC0);
  endtask

  task automatic t_sense_off;
    logic [31:0] d;
    line_in[5] = 1; cycles(4);
    rd(9'h104, d); check("R6 monitor line5", d[5], 1);
    line_in[5] = 0; cycles(4);
    rd(9'h100, d); check("R10 sense zero", d[5], 0);
    check("R7 upper bits inert", irq_out[5], 0);
  endtask

  task automatic t_rising;
    logic [31:0] d;
    wr(cfg_a(1), 32'h08);
    wr(9'h008, 32'h2);
    line_in[1] = 1;
    cycles(1);
    rd(9'h104, d); check("R6 not after one edge", d[1], 0);
    cycles(1);
    rd(9'h104, d); check("R6 after two edges", d[1], 1);
    rd(9'h100, d); check("R8 rise not yet", d[1], 0);
    cycles(1);
    rd(9'h100, d); check("R8 rise latency", d[1], 1);
    check("R5 irq_out", irq_out[1], 1);
    rd(9'h000, d); check("R5 req status", d, 32'h2);
    wr(9'h100, 32'hFFFF_FFFD);
    rd(9'h100, d); check("R4 write zero keeps", d[1], 1);
    wr(9'h100, 32'h2);
    rd(9'h100, d); check("R4 w1c", d[1], 0);
    check("R5 irq drops", irq_out[1], 0);
    line_in[1] = 0; cycles(4);
    rd(9'h100, d); check("R8 rise ignores fall", d[1], 0);
    line_in[1] = 1; cycles(4);
    wr(9'h004, 32'h2);
    rd(9'h100, d); check("R5 detect while disabled", d[1], 1);
    check("R5 masked irq", irq_out[1], 0);
    rd(9'h000, d); check("R5 masked req", d[1], 0);
    wr(9'h100, 32'h2);
  endtask

  task automatic t_falling_both;
    logic [31:0] d;
    wr(cfg_a(2), 32'h04);
    wr(cfg_a(3), 32'h0C);
    line_in[2] = 1; line_in[3] = 1; cycles(4);
    rd(9'h100, d); check("R8 fall ignores rise", d[2], 0);
    check("R8 both sees rise", d[3], 1);
    wr(9'h100, 32'h8);
    line_in[2] = 0; line_in[3] = 0;
    cycles(2);
    rd(9'h100, d); check("R8 fall not yet", d[2], 0);
    cycles(1);
    rd(9'h100, d); check("R8 fall latency", d[2], 1);
    check("R8 both sees fall", d[3], 1);
    wr(9'h100, 32'hC);
  endtask

  task automatic t_high_level;
    logic [31:0] d;
    wr(cfg_a(4), 32'h02);
    line_in[4] = 1; cycles(4);
    rd(9'h100, d); check("R8 high level", d[4], 1);
    wr(9'h100, 32'h10);
    rd(9'h100, d); check("R9 level persists", d[4], 1);
    line_in[4] = 0; cycles(4);
    wr(9'h100, 32'h10);
    rd(9'h100, d); check("R9 clear after level gone", d[4], 0);
    cycles(3);
    rd(9'h100, d); check("R9 stays clear", d[4], 0);
  endtask

  task automatic t_low_level;
    logic [31:0] d;
    wr(cfg_a(6), 32'h01);
    cycles(1);
    rd(9'h100, d); check("R8 low level", d[6], 1);
    line_in[6] = 1; cycles(4);
    wr(9'h100, 32'h40);
    rd(9'h100, d); check("R9 low gone clears", d[6], 0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    wr(cfg_a(7), 32'h08);
    line_in[7] = 1; cycles(4);
    line_in[7] = 0; cycles(4);
    rd(9'h100, d); check("R11 primed", d[7], 1);
    line_in[7] = 1;
    @(posedge clk);
    @(posedge clk);
    wr(9'h100, 32'h80);
    rd(9'h100, d); check("R11 set beats clear", d[7], 1);
    wr(9'h100, 32'h80);
    rd(9'h100, d); check("R11 later clear works", d[7], 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    cycles(1);
    t_reset();
    t_enable();
    t_config_unmapped();
    t_sense_off();
    t_rising();
    t_falling_both();
    t_high_level();
    t_low_level();
    t_set_wins();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule